// File: doc/BRIEF.md
# Variable-Length SPI Bit Transfer Engine

This block runs one SPI transaction whose write and read lengths are counted in bits rather than bytes. A surrounding sequencer places a small command packet in a byte-wide buffer and pulses `start`. The engine fetches the packet header through a buffer port and checks the opcode and both lengths. It then clocks out the requested number of write bits, clocks in the requested number of read bits, and writes the captured bits back into the read area of the same packet.

The packet begins at buffer address 0. Address 0 holds the opcode (B0h), address 1 the write bit count n, and address 2 the read bit count m. The write array starts at address 3 and fills ceil(n/8) bytes. The read array follows it directly and fills ceil(m/8) bytes. A zero count leaves out both that array and that bus phase. Chip-select is handled by other commands and is assumed to be asserted throughout. The serial clock is derived from the system clock by a half-period divider, `HALF_CYC`. Its default of 933 cycles keeps SCK at or below 134 kHz with a 250 MHz system clock.

Top module: `spi_bit_engine`

## Requirements
- R1: In idle, a `start` pulse begins a command. The engine reads address 0 (opcode), address 1 (write count) and address 2 (read count). `busy` is high from the cycle after `start` until the command ends. `done` is a single-cycle pulse during the last busy cycle.
- R2: The write phase sends exactly n bits (1 to 64), starting with bit 7 of the byte at address 3 and going MSB-first through consecutive bytes. Padding bits beyond n are never sent. When n = 0 there is no write phase.
- R3: After the write phase, and with no other activity in between, the read phase captures exactly m bits (1 to 64). Read bit k is written to bit 7-(k mod 8) of byte 3+ceil(n/8)+floor(k/8). When m = 0 there is no read phase and the buffer is not written.
- R4: Bit positions of the last read byte that lie beyond m are written as 1. No byte outside the read array is ever written.
- R5: The bus runs in SPI mode 0. SCK is low whenever the engine is not busy. MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge.
- R6: Every SCK high phase lasts exactly `HALF_CYC` clock cycles. Every SCK low phase that ends in a rising edge lasts at least `HALF_CYC` cycles.
- R7: MOSI is held at 1 during the read phase and whenever the engine is not busy.
- R8: An opcode other than B0h, or a write or read count above 64, ends the command with no SCK edge and no buffer write. In that case `err` is 1 during the `done` cycle. `err` keeps its value until the next accepted `start` clears it, and it is 0 at the end of a valid command.
- R9: A `start` pulse that arrives while the engine is busy, including the `done` cycle, is ignored. It neither restarts the command nor queues a new one.
- R10: During and after reset, `busy`, `done`, `err` and `sck` are 0 and `mosi` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a command when idle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Command was rejected (valid during and after `done`) |
| bufAddr | output | ADDR_W (5) | Byte address into the packet buffer |
| bufRdData | input | 8 | Buffer byte at `bufAddr`, same cycle |
| bufWrEn | output | 1 | Write `bufWrData` to `bufAddr` at the clock edge |
| bufWrData | output | 8 | Captured read byte |
| sck | output | 1 | SPI serial clock, idles low |
| mosi | output | 1 | SPI data out, idles high |
| miso | input | 1 | SPI data in |

## Verification
Assertions check several properties on every cycle: the SCK high-phase length and the minimum low-phase length, MOSI holding steady while SCK is high, the idle levels of SCK and MOSI, `done` lasting a single cycle, `err` only rising at `done`, buffer writes staying inside the read array, and a `start` during a command never restarting the fetch. The scenarios are the only place to check bit-level results. These cover the exact bits shifted out for odd counts, the MSB-first placement of captured bits with 1-padding, the gapless handover from write to read, the skipping of zero-length phases, and rejected packets leaving the bus and buffer untouched.

// File: rtl/spibit_pkg.sv
package spibit_pkg;

  localparam logic [7:0] OPC_BITXFER = 8'hB0;
  localparam int         HDR_BYTES   = 3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OP,
    S_WLEN,
    S_RLEN,
    S_LOAD,
    S_TXLO,
    S_TXHI,
    S_RXLO,
    S_RXHI,
    S_STORE,
    S_DONE
  } state_e;

  // Strobes from control to datapath, at most a few set in any cycle
  typedef struct packed {
    logic loadTx;    // take a fresh write byte, drive its MSB
    logic shiftTx;   // advance to the next write bit
    logic mosiIdle;  // park MOSI high
    logic sckRise;
    logic sckFall;
    logic capBit;    // sample MISO into the capture byte
    logic capClr;    // preset the capture byte to all ones
  } dpCtl_t;

endpackage

// File: rtl/spibit_halfper.sv
module spibit_halfper #(
  parameter int HALF_CYC = 933,
  localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || expire)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HALF_CYC - 1));

endmodule

// File: rtl/spibit_dp.sv
module spibit_dp
  import spibit_pkg::*;
#(
  parameter int HALF_CYC = 933,
  localparam int HW = $clog2(HALF_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpCtl_t     ctl,
  input  logic [7:0] txByte,
  input  logic [2:0] capIdx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] capByte
);

  logic [7:0] txSh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txSh <= '0;
      mosi <= 1'b1;
    end else if (ctl.loadTx) begin
      txSh <= txByte;
      mosi <= txByte[7];
    end else if (ctl.shiftTx) begin
      mosi <= txSh[6];
      txSh <= {txSh[6:0], 1'b0};
    end else if (ctl.mosiIdle) begin
      mosi <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sck <= 1'b0;
    else if (ctl.sckRise) sck <= 1'b1;
    else if (ctl.sckFall) sck <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          capByte <= 8'hFF;
    else if (ctl.capClr) capByte <= 8'hFF;
    else if (ctl.capBit) capByte[3'd7 - capIdx] <= miso;
  end

  // Phase-length monitors for the checks below
  logic [HW-1:0] hiCnt, loCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else begin
      hiCnt <= sck ? hiCnt + 1'b1 : '0;
      if (sck)                          loCnt <= '0;
      else if (loCnt != HW'(HALF_CYC))  loCnt <= loCnt + 1'b1;
    end
  end

  // R6
  hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sckFall |-> (sck && hiCnt == HW'(HALF_CYC - 1)));

  // R6
  lo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sckRise |-> (!sck && loCnt >= HW'(HALF_CYC - 1)));

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spibit_ctrl.sv
module spibit_ctrl
  import spibit_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int ADDR_W   = 5,
  localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        bufRdData,
  input  logic              expire,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufWrEn,
  output logic              timerRun,
  output dpCtl_t            ctl,
  output logic [2:0]        capIdx,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [7:0] LEN_MAX = 8'(MAX_BITS);
  localparam logic [7:0] HDR8    = 8'(HDR_BYTES);

  state_e           state, stateN;
  logic [7:0]       wLen, rLen;
  logic [CNT_W-1:0] bitIdx, bitIdxN, nextIdx, prevIdx;
  logic             errQ, errN;
  logic [7:0]       curLen, wBytes, rBytes, rxBase, txAddr8, rxAddr8;
  logic             lastBit, byteEnd, lenBad, inRead;

  assign inRead  = (state == S_RXLO) || (state == S_RXHI) || (state == S_STORE);
  assign curLen  = inRead ? rLen : wLen;
  assign nextIdx = bitIdx + 1'b1;
  assign prevIdx = bitIdx - 1'b1;
  assign lastBit = (8'(nextIdx) == curLen);
  assign byteEnd = (nextIdx[2:0] == 3'd0);
  assign wBytes  = (wLen + 8'd7) >> 3;
  assign rBytes  = (rLen + 8'd7) >> 3;
  assign rxBase  = HDR8 + wBytes;
  assign txAddr8 = HDR8 + 8'(bitIdx >> 3);
  assign rxAddr8 = rxBase + 8'(prevIdx >> 3);
  assign lenBad  = (wLen > LEN_MAX) || (bufRdData > LEN_MAX);
  assign capIdx  = bitIdx[2:0];

  always_comb begin
    stateN   = state;
    bitIdxN  = bitIdx;
    errN     = errQ;
    ctl      = '0;
    timerRun = 1'b0;
    bufAddr  = '0;
    bufWrEn  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stateN     = S_OP;
          errN       = 1'b0;
          ctl.capClr = 1'b1;
        end
      end
      S_OP: begin
        bufAddr = ADDR_W'(0);
        if (bufRdData != OPC_BITXFER) begin
          errN   = 1'b1;
          stateN = S_DONE;
        end else begin
          stateN = S_WLEN;
        end
      end
      S_WLEN: begin
        bufAddr = ADDR_W'(1);
        stateN  = S_RLEN;
      end
      S_RLEN: begin
        bufAddr = ADDR_W'(2);
        bitIdxN = '0;
        if (lenBad) begin
          errN   = 1'b1;
          stateN = S_DONE;
        end else if (wLen != 8'd0)      stateN = S_LOAD;
        else if (bufRdData != 8'd0)     stateN = S_RXLO;
        else                            stateN = S_DONE;
      end
      S_LOAD: begin
        bufAddr    = ADDR_W'(txAddr8);
        ctl.loadTx = 1'b1;
        stateN     = S_TXLO;
      end
      S_TXLO: begin
        timerRun = 1'b1;
        if (expire) begin
          ctl.sckRise = 1'b1;
          stateN      = S_TXHI;
        end
      end
      S_TXHI: begin
        timerRun = 1'b1;
        if (expire) begin
          ctl.sckFall = 1'b1;
          bitIdxN     = nextIdx;
          if (lastBit) begin
            bitIdxN      = '0;
            ctl.mosiIdle = 1'b1;
            stateN       = (rLen != 8'd0) ? S_RXLO : S_DONE;
          end else if (byteEnd) begin
            stateN = S_LOAD;
          end else begin
            ctl.shiftTx = 1'b1;
            stateN      = S_TXLO;
          end
        end
      end
      S_RXLO: begin
        timerRun = 1'b1;
        if (expire) begin
          ctl.sckRise = 1'b1;
          ctl.capBit  = 1'b1;
          stateN      = S_RXHI;
        end
      end
      S_RXHI: begin
        timerRun = 1'b1;
        if (expire) begin
          ctl.sckFall = 1'b1;
          bitIdxN     = nextIdx;
          stateN      = (lastBit || byteEnd) ? S_STORE : S_RXLO;
        end
      end
      S_STORE: begin
        bufAddr    = ADDR_W'(rxAddr8);
        bufWrEn    = 1'b1;
        ctl.capClr = 1'b1;
        stateN     = (8'(bitIdx) == rLen) ? S_DONE : S_RXLO;
      end
      S_DONE:  stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitIdx <= '0;
      errQ   <= 1'b0;
      wLen   <= '0;
      rLen   <= '0;
    end else begin
      state  <= stateN;
      bitIdx <= bitIdxN;
      errQ   <= errN;
      if (state == S_WLEN) wLen <= bufRdData;
      if (state == S_RLEN) rLen <= bufRdData;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign err  = errQ;

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && busy) |-> (done && !bufWrEn));

  // R4
  wr_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrEn |-> (8'(bufAddr) >= rxBase && 8'(bufAddr) < rxBase + rBytes));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (state != S_OP));

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spibit_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int HALF_CYC = 933,
  localparam int ADDR_W  = $clog2(HDR_BYTES + 2 * ((MAX_BITS + 7) / 8))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufRdData,
  output logic              bufWrEn,
  output logic [7:0]        bufWrData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  dpCtl_t     ctl;
  logic [2:0] capIdx;
  logic       timerRun, expire;

  spibit_ctrl #(.MAX_BITS(MAX_BITS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bufRdData(bufRdData),
    .expire(expire), .bufAddr(bufAddr), .bufWrEn(bufWrEn),
    .timerRun(timerRun), .ctl(ctl), .capIdx(capIdx),
    .busy(busy), .done(done), .err(err)
  );

  spibit_halfper #(.HALF_CYC(HALF_CYC)) u_half (
    .clk(clk), .rst_n(rst_n), .run(timerRun), .expire(expire)
  );

  spibit_dp #(.HALF_CYC(HALF_CYC)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .txByte(bufRdData),
    .capIdx(capIdx), .miso(miso), .sck(sck), .mosi(mosi), .capByte(bufWrData)
  );

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R7
  mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mosi);

endmodule

// File: tb/tb_spi_bit_engine.sv
module tb_spi_bit_engine;

  localparam int HALF = 3;

  typedef struct packed {
    logic [7:0]  n;
    logic [7:0]  m;
    logic [63:0] wdat;
    logic [63:0] spat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  8'd8,  64'hA5FF_FFFF_FFFF_FFFF, 64'h3C00_0000_0000_0000},
    '{8'd12, 8'd5,  64'hC35F_0000_0000_0000, 64'hB800_0000_0000_0000},
    '{8'd1,  8'd1,  64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
    '{8'd64, 8'd64, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
    '{8'd0,  8'd16, 64'h0000_0000_0000_0000, 64'h5AA5_0000_0000_0000},
    '{8'd16, 8'd0,  64'hBEEF_0000_0000_0000, 64'h0000_0000_0000_0000},
    '{8'd0,  8'd0,  64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    '{8'd7,  8'd9,  64'h33FF_0000_0000_0000, 64'h8080_0000_0000_0000},
    '{8'd9,  8'd64, 64'hFF80_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, err, bufWrEn, sck, mosi, miso;
  logic [4:0] bufAddr;
  logic [7:0] bufRdData, bufWrData;

  always #2 clk = ~clk;

  spi_bit_engine #(.MAX_BITS(64), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .bufAddr(bufAddr), .bufRdData(bufRdData), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // Packet buffer model
  logic [7:0] mem   [0:31];
  logic [7:0] image [0:31];
  logic       loadImg = 1'b0;
  assign bufRdData = mem[bufAddr];
  always @(posedge clk) begin
    if (loadImg) mem <= image;
    else if (bufWrEn) mem[bufAddr] <= bufWrData;
  end

  // SPI target model and bus monitor
  int          curN = 0;
  logic [63:0] curSpat = '0;
  logic        clrMeas = 1'b0;
  int riseCnt, hiRun, loRun, minHi, maxHi, minLo, holdViol, rdMosiLow, doneCnt;
  logic [63:0] txCap;
  logic prevSck, prevMosi;

  assign miso = (riseCnt >= curN && riseCnt < curN + 64) ? curSpat[63 - (riseCnt - curN)] : 1'b0;

  always @(negedge clk) begin
    if (clrMeas) begin
      riseCnt = 0; hiRun = 0; loRun = 0; minHi = 1000000; maxHi = 0;
      minLo = 1000000; holdViol = 0; rdMosiLow = 0; doneCnt = 0; txCap = '0;
    end else begin
      if (sck && !prevSck) begin
        if (riseCnt < curN) txCap[63 - riseCnt] = mosi;
        else if (!mosi) rdMosiLow++;
        riseCnt++;
      end
      if (sck) begin
        hiRun++;
        if (loRun > 0 && loRun < minLo) minLo = loRun;
        loRun = 0;
      end else begin
        if (hiRun > 0) begin
          if (hiRun < minHi) minHi = hiRun;
          if (hiRun > maxHi) maxHi = hiRun;
        end
        hiRun = 0;
        if (busy) loRun++;
      end
      if (sck && prevSck && mosi != prevMosi) holdViol++;
      if (done) doneCnt++;
    end
    prevSck = sck;
    prevMosi = mosi;
  end

  int nChk = 0;
  int nFail = 0;
  bit wd = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expTx(input logic [63:0] w, input int n);
    logic [63:0] r;
    for (int k = 0; k < 64; k++) r[63 - k] = (k < n) ? w[63 - k] : 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] expRd(input logic [63:0] s, input int m, input int j);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7 - k] = (8 * j + k < m) ? s[63 - (8 * j + k)] : 1'b1;
    return b;
  endfunction

  int  wbN, rbN;
  bit  gotDone, errAtDone;

  // Builds the packet, runs one command and waits for done.
  // poke: cycle after start at which a second start is pulsed (0 = none)
  task automatic runCase(input logic [7:0] op, input int n, input int m,
                         input logic [63:0] w, input logic [63:0] s,
                         input int poke, input bit pokeDone);
    int cyc;
    wbN = (n > 64) ? 0 : (n + 7) / 8;
    rbN = (m > 64) ? 0 : (m + 7) / 8;
    for (int a = 0; a < 32; a++) image[a] = 8'h5A;
    image[0] = op; image[1] = 8'(n); image[2] = 8'(m);
    for (int j = 0; j < wbN; j++) image[3 + j] = w[63 - 8 * j -: 8];
    for (int j = 0; j < rbN; j++) image[3 + wbN + j] = 8'hFF;
    curN = n; curSpat = s;
    @(negedge clk); loadImg = 1'b1;
    @(posedge clk); clrMeas = 1'b1;
    @(posedge clk); clrMeas = 1'b0; loadImg = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    gotDone = 1'b0; cyc = 0;
    while (!gotDone && cyc < 5000) begin
      cyc++;
      start = (poke > 0 && cyc == poke);
      if (done) begin
        gotDone = 1'b1;
        errAtDone = err;
        start = pokeDone;
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic checkBufferOutsideRead(input string req);
    int bad = 0;
    for (int a = 0; a < 32; a++)
      if (!(a >= 3 + wbN && a < 3 + wbN + rbN) && mem[a] != image[a]) bad++;
    chk(bad == 0, req, "bytes changed outside read array", 64'(bad), 64'd0);
  endtask

  initial begin
    fork
      begin
        // R10: reset values
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err, "R10", "busy/done/err in reset", {busy, done, err}, 0);
        chk(!sck && mosi, "R10", "sck/mosi in reset", {sck, mosi}, 2'b01);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !sck && mosi, "R10", "outputs after reset",
            {busy, done, err, sck, mosi}, 5'b00001);

        // Table of valid commands
        for (int v = 0; v < NV; v++) begin
          int n, m, badRd;
          n = int'(VECS[v].n); m = int'(VECS[v].m);
          runCase(8'hB0, n, m, VECS[v].wdat, VECS[v].spat, 0, 1'b0);
          chk(gotDone && doneCnt == 1, "R1", "single done pulse", 64'(doneCnt), 64'd1);
          chk(!busy, "R1", "busy after done", 64'(busy), 64'd0);
          chk(!errAtDone, "R8", "err on valid command", 64'(errAtDone), 64'd0);
          chk(riseCnt == n + m, "R2", "rising edge count", 64'(riseCnt), 64'(n + m));
          chk(txCap == expTx(VECS[v].wdat, n), "R2", "write bits on MOSI", txCap,
              expTx(VECS[v].wdat, n));
          badRd = 0;
          for (int j = 0; j < rbN; j++)
            if (mem[3 + wbN + j] != expRd(VECS[v].spat, m, j)) badRd++;
          chk(badRd == 0, "R3", "read bytes mismatching", 64'(badRd), 64'd0);
          if (m % 8 != 0)
            chk(mem[3 + wbN + rbN - 1] == expRd(VECS[v].spat, m, rbN - 1), "R4",
                "padded last read byte", 64'(mem[3 + wbN + rbN - 1]),
                64'(expRd(VECS[v].spat, m, rbN - 1)));
          checkBufferOutsideRead("R4");
          chk(holdViol == 0, "R5", "MOSI changes while SCK high", 64'(holdViol), 64'd0);
          chk(!sck && mosi, "R5", "bus idle levels after done", {sck, mosi}, 2'b01);
          if (n + m > 0) begin
            chk(minHi == HALF && maxHi == HALF, "R6", "SCK high length",
                {32'(minHi), 32'(maxHi)}, {32'(HALF), 32'(HALF)});
            chk(minLo >= HALF, "R6", "shortest SCK low", 64'(minLo), 64'(HALF));
          end
          chk(rdMosiLow == 0, "R7", "MOSI low during read phase", 64'(rdMosiLow), 64'd0);
        end

        // R8: rejected packets
        runCase(8'hB0, 65, 8, 64'hFFFF_0000_0000_0000, 64'h0, 0, 1'b0);
        chk(gotDone && errAtDone, "R8", "err for write count 65", 64'(errAtDone), 64'd1);
        chk(riseCnt == 0, "R8", "edges for write count 65", 64'(riseCnt), 64'd0);
        chk(err, "R8", "err held after done", 64'(err), 64'd1);
        wbN = 0; rbN = 0;
        checkBufferOutsideRead("R8");

        runCase(8'hB0, 8, 200, 64'hAA00_0000_0000_0000, 64'h0, 0, 1'b0);
        chk(gotDone && errAtDone && riseCnt == 0, "R8", "read count 200 rejected",
            {errAtDone, 32'(riseCnt)}, {1'b1, 32'd0});

        runCase(8'hB1, 8, 8, 64'hAA00_0000_0000_0000, 64'h0, 0, 1'b0);
        chk(gotDone && errAtDone && riseCnt == 0, "R8", "bad opcode rejected",
            {errAtDone, 32'(riseCnt)}, {1'b1, 32'd0});
        wbN = 0; rbN = 0;
        checkBufferOutsideRead("R8");

        runCase(8'hB0, 4, 4, 64'h9000_0000_0000_0000, 64'hA000_0000_0000_0000, 0, 1'b0);
        chk(gotDone && !errAtDone, "R8", "err cleared by next command", 64'(errAtDone), 64'd0);
        chk(mem[4] == 8'hAF, "R3", "4-bit read after abort", 64'(mem[4]), 64'hAF);

        // R9: start during busy and on the done cycle
        runCase(8'hB0, 12, 12, 64'h5A50_0000_0000_0000, 64'hC3C0_0000_0000_0000, 40, 1'b1);
        chk(doneCnt == 1, "R9", "done pulses with extra starts", 64'(doneCnt), 64'd1);
        chk(!busy, "R9", "busy after ignored start", 64'(busy), 64'd0);
        chk(riseCnt == 24, "R9", "edges with extra starts", 64'(riseCnt), 64'd24);
        chk(txCap == expTx(64'h5A50_0000_0000_0000, 12), "R9", "write bits unaffected",
            txCap, expTx(64'h5A50_0000_0000_0000, 12));
        chk(mem[5] == 8'hC3 && mem[6] == 8'hCF, "R9", "read bytes unaffected",
            {mem[5], mem[6]}, 16'hC3CF);
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    if (wd) begin
      nChk++; nFail++;
      $display("FAIL watchdog (R1) actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule